// File: doc/BRIEF.md
# Parameter Page CRC-16 Checker

This block validates a parameter page read from a flash device as it streams past. It takes one byte per valid strobe and runs a 16-bit CRC over the first `len_i` bytes. The two bytes after them are read as the stored check value, and the block compares that value with the CRC it computed. It also checks that the first four bytes carry the ASCII signature "ONFI". After the last check byte it raises `done_o` with a verdict code. The verdict is pass, signature error or CRC error.

A `start_i` pulse arms the block. The pulse reseeds the CRC register, samples the length to cover, and clears any earlier verdict. A new start pulse that arrives in the middle of a page drops the check in progress and begins a fresh one. The CRC update for a whole byte is done in a single cycle, so bytes can arrive on every clock.

Top module: `ppc_crc_check`

## Requirements
- R1: While reset is held, and after it until the first verdict, `done_o` is 0 and `result_o` is 2'b00 (no verdict).
- R2: The CRC uses polynomial 0x8005 and seed 0x4F4E. Each byte is taken MSB first. For each bit, feedback = CRC bit 15 XOR the data bit. The register then shifts left and is XORed with 0x8005 when the feedback is 1. The CRC covers bytes 0 to `len_i`-1. If the check value matches and the signature is correct, `result_o` is 2'b01 (pass).
- R3: The check value is little-endian: byte `len_i` is its low byte and byte `len_i`+1 is its high byte. If it differs from the computed CRC and the signature is correct, `result_o` is 2'b11 (CRC error).
- R4: Bytes 0 to 3 must be 0x4F, 0x4E, 0x46 and 0x49. If any of them differs, `result_o` is 2'b10 (signature error), whatever the CRC comparison gives.
- R5: `done_o` and `result_o` are registered. They change on the clock edge that accepts byte `len_i`+1, and not before it. They then hold until the next start pulse.
- R6: A start pulse aborts any check in progress, reseeds the CRC and restarts byte counting. In the next cycle `done_o` is 0 and `result_o` is 2'b00. A byte presented in the same cycle as the start pulse is ignored.
- R7: A byte is consumed only when `byte_vld_i` is 1. Idle cycles between bytes do not alter the result, and bytes may also arrive back to back, one per clock.
- R8: Bytes that arrive after a verdict, or before the first start pulse, have no effect on `done_o` or `result_o`.
- R9: `len_i` is sampled at the start pulse, and later changes to it do not affect the check in progress. The sampled value must be at least 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: reseed, sample length, clear verdict |
| len_i | input | CNT_W (9) | Number of bytes covered by the CRC |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Stream byte |
| done_o | output | 1 | Verdict available |
| result_o | output | 2 | 00 none, 01 pass, 10 signature error, 11 CRC error |

## Verification
Two cases are the hardest to reach from the ports. The first is a start pulse that lands inside a page, either on its own or in the same cycle as a valid byte. The second is a verdict being overwritten by bytes that keep arriving after it. The bench sends a page with a corrupted signature and cuts it off partway with a fresh start. It also pulses start together with a stray byte and then sends a clean page, which must pass. A pass is only possible if the bench's own model of the seeded CRC matches the design bit for bit, so every page is built with a check value that the bench computes itself.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int CRC_W = 16;
  localparam int DATA_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h4F4E;
  localparam int SIG_LEN = 4;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_PASS = 2'b01,
    RES_SIG  = 2'b10,
    RES_CRC  = 2'b11
  } res_e;

  function automatic logic [DATA_W-1:0] sig_ref(input logic [1:0] idx);
    case (idx)
      2'd0:    sig_ref = 8'h4F;
      2'd1:    sig_ref = 8'h4E;
      2'd2:    sig_ref = 8'h46;
      default: sig_ref = 8'h49;
    endcase
  endfunction
endpackage

// File: rtl/ppc_crc_step.sv
module ppc_crc_step #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [0:DATA_W];
  logic [DATA_W-1:0] fb;

  assign stage[0] = crc_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign fb[g] = stage[g][CRC_W-1] ^ data_i[DATA_W-1-g];
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb[g] ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/ppc_sig_match.sv
module ppc_sig_match #(
  parameter int CNT_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bad_o
);
  import ppc_pkg::*;
  localparam logic [CNT_W-1:0] SIG_N = CNT_W'(SIG_LEN);

  logic in_sig;
  logic miss;

  assign in_sig = idx_i < SIG_N;
  assign miss = data_i != sig_ref(idx_i[1:0]);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      bad_o <= 1'b0;
    end else if (en_i && in_sig && miss) begin
      bad_o <= 1'b1;
    end
  end

  // R6
  sig_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !bad_o);
endmodule

// File: rtl/ppc_ctrl.sv
module ppc_ctrl #(
  parameter int CNT_W = 9,
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] SEED = 16'h4F4E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_next_i,
  input  logic              sig_bad_i,
  output logic [CRC_W-1:0]  crc_q_o,
  output logic              take_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  import ppc_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_LO, S_HI} phase_e;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;
  logic [DATA_W-1:0] lo_q;
  logic              acc;
  logic [CRC_W-1:0]  stored;

  assign acc = vld_i && !start_i;
  assign take_o = acc && (phase == S_BODY);
  assign idx_o = cnt;
  assign stored = {data_i, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      len_q    <= '0;
      lo_q     <= '0;
      crc_q_o  <= SEED;
      done_o   <= 1'b0;
      result_o <= RES_NONE;
    end else if (start_i) begin
      phase    <= (len_i == '0) ? S_LO : S_BODY;
      cnt      <= '0;
      len_q    <= len_i;
      crc_q_o  <= SEED;
      done_o   <= 1'b0;
      result_o <= RES_NONE;
    end else if (acc) begin
      case (phase)
        S_BODY: begin
          crc_q_o <= crc_next_i;
          cnt     <= cnt + 1'b1;
          if (cnt == len_q - 1'b1) phase <= S_LO;
        end
        S_LO: begin
          lo_q  <= data_i;
          phase <= S_HI;
        end
        S_HI: begin
          phase  <= S_IDLE;
          done_o <= 1'b1;
          if (sig_bad_i)              result_o <= RES_SIG;
          else if (stored == crc_q_o) result_o <= RES_PASS;
          else                        result_o <= RES_CRC;
        end
        default: ;
      endcase
    end
  end

  // R5
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(result_o)));
  // R6
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!done_o && result_o == RES_NONE));
  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == S_BODY) |-> (cnt < len_q));
  // R1
  verdict_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done_o == (result_o != RES_NONE));
endmodule

// File: rtl/ppc_crc_check.sv
module ppc_crc_check #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic [1:0]       result_o
);
  import ppc_pkg::*;

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;
  logic             take;
  logic [CNT_W-1:0] idx;
  logic             sig_bad;

  ppc_crc_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(CRC_POLY)) u_step (
    .crc_i  (crc_q),
    .data_i (byte_i),
    .crc_o  (crc_next)
  );

  ppc_sig_match #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_sig (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (start_i),
    .en_i   (take),
    .idx_i  (idx),
    .data_i (byte_i),
    .bad_o  (sig_bad)
  );

  ppc_ctrl #(.CNT_W(CNT_W), .CRC_W(CRC_W), .DATA_W(DATA_W), .SEED(CRC_SEED)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_i      (len_i),
    .vld_i      (byte_vld_i),
    .data_i     (byte_i),
    .crc_next_i (crc_next),
    .sig_bad_i  (sig_bad),
    .crc_q_o    (crc_q),
    .take_o     (take),
    .idx_o      (idx),
    .done_o     (done_o),
    .result_o   (result_o)
  );
endmodule

// File: tb/tb_ppc_crc_check.sv
module tb_ppc_crc_check;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [8:0] len_i = 9'd0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       done_o;
  logic [1:0] result_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] pg [0:259];

  ppc_crc_check dut (.*);

  always #2 clk = ~clk;

  // len(9) mode(3) gap(1) pat(8) exp(2)
  // mode: 0 good, 1 bad signature, 2 bad check value, 3 both, 4 swapped check bytes
  localparam int NV = 9;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {9'd254, 3'd0, 1'b0, 8'h11, 2'b01},
    {9'd254, 3'd1, 1'b0, 8'h23, 2'b10},
    {9'd254, 3'd2, 1'b0, 8'h35, 2'b11},
    {9'd254, 3'd3, 1'b1, 8'h47, 2'b10},
    {9'd254, 3'd4, 1'b0, 8'h59, 2'b11},
    {9'd4,   3'd0, 1'b0, 8'h00, 2'b01},
    {9'd5,   3'd2, 1'b1, 8'h6B, 2'b11},
    {9'd100, 3'd0, 1'b1, 8'h7D, 2'b01},
    {9'd17,  3'd1, 1'b1, 8'h13, 2'b10}
  };

  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] c;
    logic fb;
    c = 16'h4F4E;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ pg[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  task automatic build(int n, int mode, logic [7:0] pat);
    logic [15:0] c;
    logic [7:0] t;
    for (int i = 0; i < 260; i++) pg[i] = 8'((i * pat) + 8'h3B) ^ 8'(i >> 1);
    pg[0] = 8'h4F; pg[1] = 8'h4E; pg[2] = 8'h46; pg[3] = 8'h49;
    if (mode == 1 || mode == 3) pg[2] = pg[2] ^ 8'h01;
    c = ref_crc(n);
    pg[n] = c[7:0];
    pg[n+1] = c[15:8];
    if (mode == 2 || mode == 3) pg[n] = pg[n] ^ 8'h20;
    if (mode == 4) begin
      t = pg[n]; pg[n] = pg[n+1]; pg[n+1] = t;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(int n, bit with_byte);
    @(negedge clk);
    start_i = 1'b1; len_i = 9'(n);
    byte_vld_i = with_byte; byte_i = 8'hAA;
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  // sends pg[first..last]; leaves the strobe on the last byte, and the caller's
  // next negedge (after the accepting edge) observes the verdict
  task automatic send(int first, int last, bit gap);
    for (int i = first; i <= last; i++) begin
      if (i != first) @(negedge clk);
      byte_vld_i = 1'b1; byte_i = pg[i];
      if (gap && i[0] && i != last) begin
        @(negedge clk);
        byte_vld_i = 1'b0;
      end
    end
  endtask

  task automatic finish_send();
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset result", result_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset result", result_o, 0);

    // R8: a full valid page before any start has no effect
    build(254, 0, 8'h11);
    send(0, 255, 1'b0);
    finish_send();
    @(negedge clk);
    chk("R8 no start done", done_o, 0);
    chk("R8 no start result", result_o, 0);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      int n;
      int md;
      logic [1:0] ex;
      n = int'(VEC[v][22:14]);
      md = int'(VEC[v][13:11]);
      ex = VEC[v][1:0];
      build(n, md, VEC[v][9:2]);
      if (md == 4 && pg[n] == pg[n+1]) ex = 2'b01;
      pulse_start(n, 1'b0);
      send(0, n + 1, VEC[v][10]);
      chk($sformatf("R5 vec%0d not done before last edge", v), done_o, 0);
      finish_send();
      chk($sformatf("R5 vec%0d done", v), done_o, 1);
      chk($sformatf("R2 R3 R4 R7 vec%0d result", v), result_o, ex);
    end

    // R8: bytes after a verdict leave it unchanged (last verdict was signature error)
    build(254, 0, 8'h11);
    send(0, 255, 1'b0);
    finish_send();
    @(negedge clk);
    chk("R8 after verdict done", done_o, 1);
    chk("R8 after verdict result", result_o, 2'b10);

    // R6: start clears verdict next cycle
    pulse_start(254, 1'b0);
    chk("R6 start clears done", done_o, 0);
    chk("R6 start clears result", result_o, 0);

    // R6: abort mid-stream (bad signature page) then a clean page passes
    build(254, 1, 8'h23);
    send(0, 100, 1'b0);
    finish_send();
    build(254, 0, 8'h35);
    pulse_start(254, 1'b0);
    send(0, 255, 1'b0);
    finish_send();
    chk("R6 abort then pass", result_o, 2'b01);

    // R6: byte in the start cycle is ignored
    build(30, 0, 8'h77);
    pulse_start(30, 1'b1);
    send(0, 31, 1'b0);
    finish_send();
    chk("R6 start-cycle byte ignored", result_o, 2'b01);

    // R9: length change mid-stream has no effect
    build(254, 0, 8'h5A);
    pulse_start(254, 1'b0);
    send(0, 9, 1'b0);
    len_i = 9'd50;
    @(negedge clk);
    send(10, 255, 1'b1);
    finish_send();
    chk("R9 len change done", done_o, 1);
    chk("R9 len change result", result_o, 2'b01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule